// File: doc/BRIEF.md
# Counter Line Verify-and-Lock Unit

This block sits on the metadata path of a memory integrity tree. Each metadata line is 512 bits wide and is split into eight 64-bit slots. Every slot carries one 56-bit version counter and a 7-bit slice of a 56-bit authentication tag that is embedded in the line. One bit of each slot is unused. The block takes a fetched line together with a tag that a separate MAC engine computed over it. It rebuilds the embedded tag from the eight slices and compares the two tags.

When the tags match, a read request returns the line in normalised form, with every unused bit cleared. A write request returns the line with one chosen counter incremented by one. When the tags differ, no data is returned. The block then enters a sticky locked state in which every later request is answered as refused, and only a reset leaves that state. Keys are assumed to be regenerated at reset. A counter that is already all ones is never wrapped: the request is reported as an overflow and the line comes back unchanged.

The request port uses a valid/ready handshake and ready is held high. Every accepted request produces exactly one registered response in the following cycle.

Top module: `ctr_line_guard`

## Requirements
- R1: In every slot s (bits [64s+63:64s] of the line), bits [55:0] hold counter s, bits [62:56] hold tag bits [7s+6:7s], and bit 63 is unused. Every response line has bit 63 of every slot equal to zero.
- R2: Each cycle with `req_valid` high gives `rsp_valid` high in the next cycle. A cycle without a request gives `rsp_valid` low in the next cycle.
- R3: A read (`req_op`=0) whose embedded tag equals `req_tag` returns status OK (2'b00). The response line carries the same counters and the same tag as the request line.
- R4: A write (`req_op`=1) whose tag matches, on a counter that is not all ones, returns status OK (2'b00). The counter selected by `req_idx` is increased by one, with the carry running across all 56 bits, and every other counter and the tag are unchanged.
- R5: A write whose tag matches, on a counter that is all ones, returns status OVERFLOW (2'b01). The response line is the request line unchanged apart from the cleared unused bits, and the lock is not set.
- R6: A tag mismatch returns status MISMATCH (2'b10) with an all-zero line and sets `lock_o` from that response onward. A mismatch takes priority over an overflow.
- R7: While `lock_o` is high, `req_ready` stays high and every request returns status LOCKED (2'b11) with an all-zero line, even when its tag matches.
- R8: `lock_o` clears only on a synchronous reset and otherwise never falls. After reset `lock_o`, `rsp_valid` and `rsp_status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_op | input | 1 | 0 = verify and read, 1 = verify and increment |
| req_idx | input | 3 | Counter slot chosen for increment |
| req_line | input | 512 | Fetched metadata line |
| req_tag | input | 56 | Tag computed externally over the line |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 00 OK, 01 overflow, 10 mismatch, 11 locked |
| rsp_line | output | 512 | Normalised or updated line, zero unless OK or overflow |
| lock_o | output | 1 | Sticky lock flag |

## Verification
Two conditions can fall on the same request: a tag mismatch and a counter at its wrap limit. The bench provokes this with a write aimed at an all-ones counter while presenting a tag that differs in one bit. The response must report a mismatch rather than an overflow, return an all-zero line and raise the lock. A follow-up request with a correct tag in the very next cycle must already be refused. This second step checks the boundary between the cycle that sets the lock and the first cycle that obeys it.

// File: rtl/ctr_line_pkg.sv
package ctr_line_pkg;
  localparam int SLOTS   = 8;
  localparam int CTR_W   = 56;
  localparam int SLICE_W = 7;
  localparam int SLOT_W  = 64;
  localparam int LINE_W  = SLOTS * SLOT_W;
  localparam int TAG_W   = SLOTS * SLICE_W;
  localparam int IDX_W   = $clog2(SLOTS);

  typedef enum logic [1:0] {
    ST_OK     = 2'b00,
    ST_OVF    = 2'b01,
    ST_BAD    = 2'b10,
    ST_LOCKED = 2'b11
  } rsp_st_e;
endpackage

// File: rtl/ctr_line_unpack.sv
module ctr_line_unpack #(
  parameter int SLOTS   = ctr_line_pkg::SLOTS,
  parameter int CTR_W   = ctr_line_pkg::CTR_W,
  parameter int SLICE_W = ctr_line_pkg::SLICE_W,
  parameter int SLOT_W  = ctr_line_pkg::SLOT_W,
  localparam int LINE_W = SLOTS * SLOT_W,
  localparam int TAG_W  = SLOTS * SLICE_W
) (
  input  logic [LINE_W-1:0]      line_i,
  output logic [SLOTS*CTR_W-1:0] ctrs_o,
  output logic [TAG_W-1:0]       tag_o
);
  // each slot yields its counter and its share of the embedded tag
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign ctrs_o[s*CTR_W +: CTR_W]    = line_i[s*SLOT_W +: CTR_W];
    assign tag_o[s*SLICE_W +: SLICE_W] = line_i[s*SLOT_W + CTR_W +: SLICE_W];
  end
endmodule

// File: rtl/ctr_line_pack.sv
module ctr_line_pack #(
  parameter int SLOTS   = ctr_line_pkg::SLOTS,
  parameter int CTR_W   = ctr_line_pkg::CTR_W,
  parameter int SLICE_W = ctr_line_pkg::SLICE_W,
  parameter int SLOT_W  = ctr_line_pkg::SLOT_W,
  localparam int LINE_W = SLOTS * SLOT_W,
  localparam int TAG_W  = SLOTS * SLICE_W,
  localparam int PAD_W  = SLOT_W - CTR_W - SLICE_W
) (
  input  logic [SLOTS*CTR_W-1:0] ctrs_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic [LINE_W-1:0]      line_o
);
  // spare bits always leave the block as zero
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign line_o[s*SLOT_W +: SLOT_W] = {{PAD_W{1'b0}},
                                         tag_i[s*SLICE_W +: SLICE_W],
                                         ctrs_i[s*CTR_W +: CTR_W]};
  end
endmodule

// File: rtl/ctr_line_bump.sv
module ctr_line_bump #(
  parameter int SLOTS = ctr_line_pkg::SLOTS,
  parameter int CTR_W = ctr_line_pkg::CTR_W,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS*CTR_W-1:0] ctrs_i,
  input  logic                   en_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic                   at_max_o,
  output logic [SLOTS*CTR_W-1:0] ctrs_o
);
  logic [SLOTS-1:0] hit;
  logic [SLOTS-1:0] full;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [CTR_W-1:0] cur;
    assign cur     = ctrs_i[s*CTR_W +: CTR_W];
    assign hit[s]  = (idx_i == IDX_W'(s));
    assign full[s] = &cur;
    // a saturated counter is held, never wrapped
    assign ctrs_o[s*CTR_W +: CTR_W] = (en_i && hit[s] && !full[s]) ? cur + 1'b1 : cur;
  end

  assign at_max_o = |(hit & full);
endmodule

// File: rtl/ctr_line_guard.sv
module ctr_line_guard #(
  parameter int SLOTS   = ctr_line_pkg::SLOTS,
  parameter int CTR_W   = ctr_line_pkg::CTR_W,
  parameter int SLICE_W = ctr_line_pkg::SLICE_W,
  parameter int SLOT_W  = ctr_line_pkg::SLOT_W,
  localparam int LINE_W = SLOTS * SLOT_W,
  localparam int TAG_W  = SLOTS * SLICE_W,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [LINE_W-1:0] req_line,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [LINE_W-1:0] rsp_line,
  output logic              lock_o
);
  import ctr_line_pkg::*;

  logic [SLOTS*CTR_W-1:0] cur_ctrs;
  logic [SLOTS*CTR_W-1:0] nxt_ctrs;
  logic [TAG_W-1:0]       emb_tag;
  logic [LINE_W-1:0]      out_line;
  logic                   at_max;
  logic                   tag_bad;

  ctr_line_unpack #(.SLOTS(SLOTS), .CTR_W(CTR_W), .SLICE_W(SLICE_W), .SLOT_W(SLOT_W)) unpack_i (
    .line_i (req_line),
    .ctrs_o (cur_ctrs),
    .tag_o  (emb_tag)
  );

  ctr_line_bump #(.SLOTS(SLOTS), .CTR_W(CTR_W)) bump_i (
    .ctrs_i   (cur_ctrs),
    .en_i     (req_op),
    .idx_i    (req_idx),
    .at_max_o (at_max),
    .ctrs_o   (nxt_ctrs)
  );

  ctr_line_pack #(.SLOTS(SLOTS), .CTR_W(CTR_W), .SLICE_W(SLICE_W), .SLOT_W(SLOT_W)) pack_i (
    .ctrs_i (nxt_ctrs),
    .tag_i  (emb_tag),
    .line_o (out_line)
  );

  assign tag_bad   = (emb_tag != req_tag);
  assign req_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_line   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (lock_o) begin
          rsp_status <= ST_LOCKED;
          rsp_line   <= '0;
        end else if (tag_bad) begin
          // drop the data and refuse everything from here on
          rsp_status <= ST_BAD;
          rsp_line   <= '0;
          lock_o     <= 1'b1;
        end else if (req_op && at_max) begin
          rsp_status <= ST_OVF;
          rsp_line   <= out_line;
        end else begin
          rsp_status <= ST_OK;
          rsp_line   <= out_line;
        end
      end
    end
  end
endmodule

// File: rtl/ctr_line_guard_chk.sv
module ctr_line_guard_chk #(
  parameter int SLOTS   = ctr_line_pkg::SLOTS,
  parameter int CTR_W   = ctr_line_pkg::CTR_W,
  parameter int SLICE_W = ctr_line_pkg::SLICE_W,
  parameter int SLOT_W  = ctr_line_pkg::SLOT_W,
  localparam int LINE_W = SLOTS * SLOT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [LINE_W-1:0] rsp_line,
  input logic              lock_o
);
  function automatic logic [LINE_W-1:0] spare_mask();
    logic [LINE_W-1:0] m;
    m = '0;
    for (int s = 0; s < SLOTS; s++)
      for (int b = CTR_W + SLICE_W; b < SLOT_W; b++)
        m[s*SLOT_W + b] = 1'b1;
    return m;
  endfunction

  localparam logic [LINE_W-1:0] SPARE = spare_mask();

  a_r1_spare_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_line & SPARE) == '0));

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r5_overflow_no_lock: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b01) |-> !lock_o);

  a_r6_mismatch_locks: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'b10) |-> (lock_o && rsp_line == '0));

  a_r6_lock_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> (rsp_valid && rsp_status == 2'b10));

  a_r7_locked_refuse: assert property (@(posedge clk) disable iff (rst)
    (req_valid && lock_o) |=> (rsp_status == 2'b11 && rsp_line == '0 && req_ready));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> lock_o);
endmodule

bind ctr_line_guard ctr_line_guard_chk #(
  .SLOTS(SLOTS), .CTR_W(CTR_W), .SLICE_W(SLICE_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_line   (rsp_line),
  .lock_o     (lock_o)
);

// File: tb/ctr_line_guard_tb_top.sv
module ctr_line_guard_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_op = 1'b0;
  logic [2:0]   req_idx = '0;
  logic [511:0] req_line = '0;
  logic [55:0]  req_tag = '0;
  logic         rsp_valid;
  logic [1:0]   rsp_status;
  logic [511:0] rsp_line;
  logic         lock_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctr_line_guard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_idx(req_idx), .req_line(req_line), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_line(rsp_line), .lock_o(lock_o)
  );

  // independent line builder following the slot layout of R1
  function automatic logic [511:0] mk_line(input logic [7:0][55:0] c, input logic [55:0] t, input bit spare);
    logic [511:0] l;
    for (int s = 0; s < 8; s++)
      l[s*64 +: 64] = {spare, t[s*7 +: 7], c[s]};
    return l;
  endfunction

  task automatic chk(input string req, input string what, input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic op, input logic [2:0] idx, input logic [511:0] line, input logic [55:0] tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_idx = idx; req_line = line; req_tag = tag;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
  endtask

  logic [7:0][55:0] base;
  logic [55:0]      btag;

  task automatic t_reset();
    chk("R8", "lock after reset", 512'(lock_o), 512'(0));
    chk("R8", "valid after reset", 512'(rsp_valid), 512'(0));
    chk("R8", "status after reset", 512'(rsp_status), 512'(0));
  endtask

  task automatic t_read();
    send(1'b0, 3'd2, mk_line(base, btag, 1'b1), btag);
    chk("R2", "valid after request", 512'(rsp_valid), 512'(1));
    chk("R3", "read status", 512'(rsp_status), 512'(0));
    chk("R1", "read line normalised", rsp_line, mk_line(base, btag, 1'b0));
    @(negedge clk); @(posedge clk); #1;
    chk("R2", "valid without request", 512'(rsp_valid), 512'(0));
  endtask

  task automatic t_write();
    logic [7:0][55:0] e;
    e = base; e[5] = e[5] + 1;
    send(1'b1, 3'd5, mk_line(base, btag, 1'b0), btag);
    chk("R4", "write status", 512'(rsp_status), 512'(0));
    chk("R4", "slot 5 incremented", rsp_line, mk_line(e, btag, 1'b0));
    e = base; e[0] = 56'h00_FFFF_FFFF_FFFF; base[0] = e[0];
    e[0] = 56'h01_0000_0000_0000;
    send(1'b1, 3'd0, mk_line(base, btag, 1'b1), btag);
    chk("R4", "carry across slot 0", rsp_line, mk_line(e, btag, 1'b0));
  endtask

  task automatic t_overflow();
    logic [7:0][55:0] c;
    c = base; c[7] = '1;
    send(1'b1, 3'd7, mk_line(c, btag, 1'b1), btag);
    chk("R5", "overflow status", 512'(rsp_status), 512'(1));
    chk("R5", "overflow line unchanged", rsp_line, mk_line(c, btag, 1'b0));
    chk("R5", "no lock on overflow", 512'(lock_o), 512'(0));
  endtask

  // mismatch and overflow on the same request, then a good request right after
  task automatic t_mismatch_and_lock();
    logic [7:0][55:0] c;
    c = base; c[7] = '1;
    send(1'b1, 3'd7, mk_line(c, btag, 1'b0), btag ^ 56'h80_0000);
    chk("R6", "mismatch wins over overflow", 512'(rsp_status), 512'(2));
    chk("R6", "mismatch data dropped", rsp_line, '0);
    chk("R6", "lock raised", 512'(lock_o), 512'(1));
    send(1'b0, 3'd0, mk_line(base, btag, 1'b0), btag);
    chk("R7", "good read refused", 512'(rsp_status), 512'(3));
    chk("R7", "refused data zero", rsp_line, '0);
    chk("R7", "ready while locked", 512'(req_ready), 512'(1));
    send(1'b1, 3'd1, mk_line(base, btag, 1'b0), btag);
    chk("R7", "write refused", 512'(rsp_status), 512'(3));
  endtask

  task automatic t_sticky();
    repeat (10) @(posedge clk);
    #1;
    chk("R8", "lock held while idle", 512'(lock_o), 512'(1));
    do_reset();
    #1;
    chk("R8", "reset clears lock", 512'(lock_o), 512'(0));
    send(1'b0, 3'd3, mk_line(base, btag, 1'b0), btag);
    chk("R8", "service after reset", 512'(rsp_status), 512'(0));
    send(1'b0, 3'd3, mk_line(base, btag, 1'b0), btag ^ 56'h1);
    chk("R6", "read mismatch status", 512'(rsp_status), 512'(2));
    chk("R6", "read mismatch locks", 512'(lock_o), 512'(1));
  endtask

  initial begin
    for (int s = 0; s < 8; s++) base[s] = 56'h1234_5600_0000 + 56'(s * 56'h1_0101_0101);
    btag = 56'hA5_C3_17_E9_42_6B_D0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_read();
    t_write();
    t_overflow();
    t_mismatch_and_lock();
    t_sticky();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule